// File: doc/BRIEF.md
# MDIO Management Register Controller

This block carries out a single clause-22 management access to an external PHY, launched from one host-visible 32-bit register. The host writes a packed command containing the operation code, the PHY address, the PHY register address and, for a write, the 16-bit payload. The controller then generates MDC from the system clock and shifts a complete management frame out on MDIO. On a read, it releases the line for the turnaround and data phases and collects the bits the PHY returns.

Once the frame is finished, a ready flag in the register is set and a one-cycle done event is raised. The host polls the ready flag, then reads the result from the low half of the same register. Reads of the PHY's second identifier register receive special handling: if the model field in the returned word is zero, a no-PHY flag is set.

Top module: `mdio_ctrl`

## Requirements
- R1: After reset the register reads 0x1000_0000 (ready set, every other bit zero), MDC is low, MDIO is not driven and the done event is low.
- R2: The register layout is as follows. Bits 27:26 hold the operation code, 01 for write and 10 for read. Bits 25:21 hold the PHY address, bits 20:16 the PHY register address and bits 15:0 the data. Bit 28 is ready and bit 29 is no-PHY. Bits 31:30 read zero. An accepted write stores bits 27:0 and clears ready on the following cycle.
- R3: While a transaction runs, MDC is low at the start and toggles every DIV_HALF system clocks. While idle, MDC is held low.
- R4: The frame has 64 bit times, sent MSB first in this order: 32 ones, start 01, operation code, PHY address, register address, two turnaround bits, 16 data bits. MDIO changes only when MDC falls.
- R5: On a write, the turnaround is driven as 10 followed by the write data, and the output enable stays high for all 64 bit times.
- R6: On a read, MDIO is released for the last 18 bit times (turnaround and data). The data bits are sampled on MDC rising edges, MSB first, and replace bits 15:0 when the transaction completes.
- R7: Completion occurs 128*DIV_HALF system clocks after the accepting edge. At that point ready sets and done_o pulses high for exactly one cycle.
- R8: A command written while a transaction is in progress is ignored. The stored fields do not change and ready stays low until the current transaction ends.
- R9: A command whose operation code is 00 or 11 is ignored. The register does not change and no frame starts.
- R10: The no-PHY flag (bit 29) is set at the end of a read of register address ID2_ADDR (default 3) whose returned bits 9:4 are all zero. Any other completion clears it, and so does any accepted command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Host write strobe for the command register |
| wr_data_i | input | 28 | Writable register bits 27:0 (operation, PHY address, register address, data) |
| rd_data_o | output | 32 | Full register contents |
| done_o | output | 1 | One-cycle management-done event |
| mdc_o | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe_o | output | 1 | MDIO output enable (low means released) |
| mdio_i | input | 1 | MDIO input from the pad |

## Verification
The bench builds the controller with DIV_HALF=2 and the default identifier address of 3. With these values each transaction takes 256 clocks, so many write and read frames fit into a short run, and every MDC edge is checked against the reference. A behavioural PHY answers read frames bit by bit. The responses are chosen to exercise the no-PHY model-field test on the identifier register in both directions, as well as on a different register. Commands with invalid operation codes and commands written during a busy frame are issued to show that neither the register nor the pins react to them.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_BITS = 64;
  localparam int PRE_BITS   = 32;
  localparam int TA_POS     = 46;
  localparam int DATA_POS   = 48;
  localparam int DATA_W     = 16;
  localparam int IDX_W      = $clog2(FRAME_BITS);

  typedef enum logic [1:0] {
    OP_WR = 2'b01,
    OP_RD = 2'b10
  } op_e;

  typedef struct packed {
    logic [1:0]        op;
    logic [4:0]        phy;
    logic [4:0]        regad;
    logic [DATA_W-1:0] data;
  } cmd_t;

  function automatic logic op_valid(input logic [1:0] op);
    return (op == OP_WR) || (op == OP_RD);
  endfunction
endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv #(
  parameter int DIV_HALF = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic mdc_o,
  output logic rise_o,
  output logic fall_o
);
  logic tick;
  logic mdc_q;

  generate
    if (DIV_HALF <= 1) begin : g_nodiv
      assign tick = run_i;
    end else begin : g_div
      localparam int CW = $clog2(DIV_HALF);
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                              cnt_q <= '0;
        else if (!run_i || tick)                  cnt_q <= '0;
        else                                      cnt_q <= cnt_q + 1'b1;
      end
      assign tick = run_i && (cnt_q == CW'(DIV_HALF - 1));
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     mdc_q <= 1'b0;
    else if (!run_i) mdc_q <= 1'b0;
    else if (tick)   mdc_q <= ~mdc_q;
  end

  assign mdc_o  = mdc_q;
  assign rise_o = tick && !mdc_q;
  assign fall_o = tick && mdc_q;
endmodule

// File: rtl/mdio_shifter.sv
module mdio_shifter
  import mdio_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  cmd_t              cmd_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              mdio_i,
  output logic              busy_o,
  output logic              mdio_o,
  output logic              mdio_oe_o,
  output logic              last_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic [FRAME_BITS-1:0] frame_q, frame_d;
  logic [IDX_W-1:0]      idx_q;
  logic                  busy_q, rd_q;
  logic [DATA_W-1:0]     cap_q;
  logic                  is_rd;

  assign is_rd = (cmd_i.op == OP_RD);

  always_comb begin
    frame_d = {{PRE_BITS{1'b1}}, 2'b01, cmd_i.op, cmd_i.phy, cmd_i.regad,
               (is_rd ? 2'b00 : 2'b10),
               (is_rd ? {DATA_W{1'b0}} : cmd_i.data)};
  end

  assign last_o = busy_q && fall_i && (idx_q == IDX_W'(FRAME_BITS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      idx_q   <= '0;
      frame_q <= '0;
      rd_q    <= 1'b0;
      cap_q   <= '0;
    end else if (start_i) begin
      busy_q  <= 1'b1;
      idx_q   <= '0;
      frame_q <= frame_d;
      rd_q    <= is_rd;
      cap_q   <= '0;
    end else if (busy_q) begin
      if (rise_i && rd_q && (idx_q >= IDX_W'(DATA_POS)))
        cap_q <= {cap_q[DATA_W-2:0], mdio_i};
      if (fall_i) begin
        if (last_o) begin
          busy_q <= 1'b0;
        end else begin
          idx_q   <= idx_q + 1'b1;
          frame_q <= {frame_q[FRAME_BITS-2:0], 1'b0};
        end
      end
    end
  end

  assign busy_o    = busy_q;
  assign mdio_o    = busy_q && frame_q[FRAME_BITS-1];
  assign mdio_oe_o = busy_q && !(rd_q && (idx_q >= IDX_W'(TA_POS)));
  assign rdata_o   = cap_q;
endmodule

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
  import mdio_pkg::*;
#(
  parameter int         DIV_HALF  = 4,
  parameter logic [4:0] ID2_ADDR  = 5'd3,
  parameter int         MODEL_LSB = 4,
  parameter int         MODEL_W   = 6
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [27:0] wr_data_i,
  output logic [31:0] rd_data_o,
  output logic        done_o,
  output logic        mdc_o,
  output logic        mdio_o,
  output logic        mdio_oe_o,
  input  logic        mdio_i
);
  cmd_t              wr_cmd, reg_q;
  logic              ready_q, absent_q, done_q;
  logic              busy, rise, fall, last, accept;
  logic [DATA_W-1:0] rdata;

  assign wr_cmd = cmd_t'(wr_data_i);
  assign accept = wr_en_i && !busy && op_valid(wr_cmd.op);

  mdio_clkdiv #(.DIV_HALF(DIV_HALF)) u_div (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (busy),
    .mdc_o (mdc_o),
    .rise_o(rise),
    .fall_o(fall)
  );

  mdio_shifter u_shift (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (accept),
    .cmd_i    (wr_cmd),
    .rise_i   (rise),
    .fall_i   (fall),
    .mdio_i   (mdio_i),
    .busy_o   (busy),
    .mdio_o   (mdio_o),
    .mdio_oe_o(mdio_oe_o),
    .last_o   (last),
    .rdata_o  (rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reg_q    <= '0;
      ready_q  <= 1'b1;
      absent_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= last;
      if (accept) begin
        reg_q    <= wr_cmd;
        ready_q  <= 1'b0;
        absent_q <= 1'b0;
      end else if (last) begin
        ready_q <= 1'b1;
        if (reg_q.op == OP_RD) begin
          reg_q.data <= rdata;
          absent_q   <= (reg_q.regad == ID2_ADDR) &&
                        (rdata[MODEL_LSB +: MODEL_W] == '0);
        end
      end
    end
  end

  assign rd_data_o = {2'b00, absent_q, ready_q, reg_q};
  assign done_o    = done_q;
endmodule

// File: rtl/mdio_ctrl_chk.sv
module mdio_ctrl_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wr_en_i,
  input logic [31:0] rd_data_o,
  input logic        done_o,
  input logic        mdc_o,
  input logic        mdio_o,
  input logic        mdio_oe_o
);
  assert_done_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_done_ready_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> rd_data_o[28]);
  assert_idle_quiet_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[28] |-> (!mdio_oe_o && !mdc_o));
  assert_stable_rise_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mdc_o) |-> ($stable(mdio_o) && $stable(mdio_oe_o)));
  assert_ready_fall_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rd_data_o[28]) |-> $past(wr_en_i));
  assert_hi_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[31:30] == 2'b00);
endmodule

bind mdio_ctrl mdio_ctrl_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .wr_en_i  (wr_en_i),
  .rd_data_o(rd_data_o),
  .done_o   (done_o),
  .mdc_o    (mdc_o),
  .mdio_o   (mdio_o),
  .mdio_oe_o(mdio_oe_o)
);

// File: tb/tb_mdio_ctrl.sv
`timescale 1ns/1ps
module tb_mdio_ctrl;
  localparam int D   = 2;
  localparam int TXN = 128 * D;

  logic        clk = 1'b0, rst_ni = 1'b0, wr_en = 1'b0, mdio_i = 1'b1;
  logic [27:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        done, mdc, mdio_o, mdio_oe;

  always #2.5 clk = ~clk;

  mdio_ctrl #(.DIV_HALF(D)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_data_o(rd_data), .done_o(done), .mdc_o(mdc), .mdio_o(mdio_o),
    .mdio_oe_o(mdio_oe), .mdio_i(mdio_i)
  );

  int checks = 0, fails = 0, k = 0, idx = 0;
  bit m_busy = 0, m_ready = 1, m_absent = 0, m_done = 0;
  logic [1:0]  m_op = '0;
  logic [4:0]  m_phy = '0, m_reg = '0;
  logic [15:0] m_data = '0, phy_resp = '0;
  logic [63:0] m_frame = '0;
  logic [31:0] snap;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model: k counts clocks since the accepting edge
  always @(posedge clk) begin
    if (rst_ni) begin
      m_done = 0;
      if (m_busy) begin
        k++;
        if (k == TXN) begin
          m_busy = 0; m_done = 1; m_ready = 1;
          if (m_op == 2'b10) begin
            m_data   = phy_resp;
            m_absent = (m_reg == 5'd3) && (phy_resp[9:4] == 6'd0);
          end
        end
      end else if (wr_en && (wr_data[27:26] == 2'b01 || wr_data[27:26] == 2'b10)) begin
        m_busy = 1; k = 0; m_ready = 0; m_absent = 0;
        {m_op, m_phy, m_reg, m_data} = wr_data;
        m_frame = {32'hFFFF_FFFF, 2'b01, m_op, m_phy, m_reg,
                   (m_op == 2'b10) ? 2'b00 : 2'b10,
                   (m_op == 2'b10) ? 16'h0 : m_data};
      end
    end
  end

  always @(negedge clk) begin
    if (rst_ni) begin
      idx = k / (2 * D);
      chk("R3 mdc", 32'(mdc), m_busy ? 32'((k / D) % 2) : 32'd0);
      chk("R5/R6 oe", 32'(mdio_oe), 32'(m_busy && !(m_op == 2'b10 && idx >= 46)));
      if (m_busy && mdio_oe) chk("R4 mdio", 32'(mdio_o), 32'(m_frame[63 - idx]));
      chk("R7 done", 32'(done), 32'(m_done));
      chk("R2 register", rd_data, {2'b00, m_absent, m_ready, m_op, m_phy, m_reg, m_data});
      mdio_i = (m_busy && idx >= 48) ? phy_resp[15 - (idx - 48)] : 1'b1;
    end
  end

  task automatic issue(input logic [27:0] w);
    @(negedge clk); wr_en = 1'b1; wr_data = w;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (m_busy);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R7 watchdog act=timeout exp=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 reset reg", rd_data, 32'h1000_0000);
    chk("R1 reset mdc", 32'(mdc), 32'd0);
    chk("R1 reset oe", 32'(mdio_oe), 32'd0);
    chk("R1 reset done", 32'(done), 32'd0);

    // R2 / R5: write frame
    issue({2'b01, 5'd5, 5'h12, 16'hA5C3});
    chk("R2 accept", rd_data, {4'b0000, 2'b01, 5'd5, 5'h12, 16'hA5C3});
    wait_idle();
    chk("R7 write complete", rd_data, {4'b0001, 2'b01, 5'd5, 5'h12, 16'hA5C3});

    // R9: invalid opcodes
    snap = rd_data;
    issue({2'b00, 5'd1, 5'd1, 16'h1111});
    repeat (6) @(negedge clk);
    chk("R9 op00 reg", rd_data, snap);
    chk("R9 op00 mdc", 32'(mdc), 32'd0);
    issue({2'b11, 5'd2, 5'd2, 16'h2222});
    repeat (6) @(negedge clk);
    chk("R9 op11 reg", rd_data, snap);
    chk("R9 op11 oe", 32'(mdio_oe), 32'd0);

    // R6 read, with R8 busy write
    phy_resp = 16'hBEEF;
    issue({2'b10, 5'd1, 5'd2, 16'h1234});
    repeat (20) @(negedge clk);
    issue({2'b01, 5'd7, 5'd9, 16'h5555});
    chk("R8 busy ignored", rd_data, {4'b0000, 2'b10, 5'd1, 5'd2, 16'h1234});
    wait_idle();
    chk("R6 read data", 32'(rd_data[15:0]), 32'h0000_BEEF);
    chk("R10 other reg flag", 32'(rd_data[29]), 32'd0);

    // R10: identifier register with zero model field
    phy_resp = 16'h000F;
    issue({2'b10, 5'd4, 5'd3, 16'h0});
    wait_idle();
    chk("R10 absent set", rd_data, {4'b0011, 2'b10, 5'd4, 5'd3, 16'h000F});
    phy_resp = 16'h0230;
    issue({2'b10, 5'd4, 5'd3, 16'h0});
    chk("R10 cleared on accept", 32'(rd_data[29]), 32'd0);
    wait_idle();
    chk("R10 model nonzero", 32'(rd_data[29]), 32'd0);
    chk("R6 read data 2", 32'(rd_data[15:0]), 32'h0000_0230);
    phy_resp = 16'h0000;
    issue({2'b10, 5'd4, 5'd2, 16'hFFFF});
    wait_idle();
    chk("R10 non-id reg", 32'(rd_data[29]), 32'd0);
    chk("R6 read zero", 32'(rd_data[15:0]), 32'd0);

    // back-to-back write right after completion
    issue({2'b01, 5'd31, 5'd31, 16'h8001});
    wait_idle();
    chk("R5 write b2b", rd_data, {4'b0001, 2'b01, 5'd31, 5'd31, 16'h8001});
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule